// File: doc/BRIEF.md
# Stride Register and Address-Advance Unit

This unit keeps one stride value and one data-type code for each general-purpose register. It uses a single adder to walk address streams through memory. Three commands drive it:

- **Stride setup** computes a stride from a register and a signed immediate.
- **Stream start** forms a first address, records the element type and sends the first prefetch request.
- **Advance** runs when a prefetched operand is consumed. It adds the stride paired with the register to the address that register holds, sends a prefetch request for the new address, and writes the new address back into the register.

The general-purpose register file stays outside the block. The unit reaches it through one combinational read port and one registered write port. Prefetch requests leave on a valid/ready channel. When the receiver stalls, the unit holds the request and delays the register write-back, so the stored address never runs ahead of the issued requests. One command is in flight at a time, and `busy` tells the issuer when the next command can be accepted.

Top module: `stride_advance_unit`

## Requirements
- R1: Stride setup (cmd_op = 1) stores `GPR[cmd_rs] + sign_extend(cmd_imm)` as the stride paired with register `cmd_rd`. It issues no request and writes no register.
- R2: Stream start (cmd_op = 2) computes `A = GPR[cmd_rs] + sign_extend(cmd_imm)`. It issues one request with address A, type `cmd_dtype` and slot `cmd_rd`, and afterwards writes A into `GPR[cmd_rd]`.
- R3: Advance (cmd_op = 3) computes `A = GPR[cmd_rd] + stride[cmd_rd]`. It issues one request with address A and slot `cmd_rd`, and afterwards writes A into `GPR[cmd_rd]`. Repeated advances step by the stride each time.
- R4: The type code recorded by a stream start is attached to every later advance request for that register. `cmd_dtype` has no effect on an advance.
- R5: Each register uses only its own stride. Setting up or using one entry leaves the stride of every other entry unchanged.
- R6: Strides and immediates are signed. Address sums are 32-bit two's complement and wrap silently, so streams may walk downward or cross address zero.
- R7: While `req_valid` is high and `req_ready` is low, the request address stays stable, `busy` stays high and no register write occurs. The write-back happens in the cycle after the handshake.
- R8: After reset, `busy`, `req_valid` and `gpr_we` are low. A command presented while `busy` is high is ignored.
- R9: For an accepted start or advance, `req_valid` rises two clock edges after the accepting edge. With `req_ready` high, `gpr_we` is high for exactly one cycle after the handshake edge, and `busy` falls at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present; taken when busy is low |
| cmd_op | input | 2 | 0 none, 1 stride setup, 2 stream start, 3 advance |
| cmd_rd | input | IW | Target register / stride entry |
| cmd_rs | input | IW | Source register for setup and start |
| cmd_imm | input | IMMW | Signed immediate or offset |
| cmd_dtype | input | DTW | Element type code for stream start |
| busy | output | 1 | A command is in progress |
| gpr_raddr | output | IW | Register file read index |
| gpr_rdata | input | AW | Register file read data (combinational) |
| gpr_we | output | 1 | Register file write enable |
| gpr_waddr | output | IW | Register file write index |
| gpr_wdata | output | AW | Register file write data |
| req_valid | output | 1 | Prefetch request valid |
| req_ready | input | 1 | Prefetch request accepted |
| req_addr | output | AW | Prefetch address |
| req_dtype | output | DTW | Element type code of the request |
| req_slot | output | IW | Register the request belongs to |

## Verification
The bench exercises the adder with three kinds of input:
- **Upward stream.** A positive stride of 4 climbs by word, which separates correct stride pairing from use of the raw immediate.
- **Downward stream.** A negative stride on a second register, interleaved with the first, catches strides read from the wrong entry and shows whether sign handling is correct.
- **Wrap streams.** A start near the top of the address space, and a negative offset from zero, show whether the sum wraps at 32 bits.

Two control cases round this out. A held-off ready tells a stable, delayed write-back apart from an early one. A command presented while busy must leave the request count and the register file untouched.

// File: rtl/sau_pkg.sv
package sau_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_STRIDE  = 2'd1,
    OP_START   = 2'd2,
    OP_ADVANCE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EXEC  = 2'd1,
    ST_ISSUE = 2'd2,
    ST_WB    = 2'd3
  } st_e;
endpackage

// File: rtl/sau_slot_ram.sv
module sau_slot_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sau_addr_adder.sv
module sau_addr_adder #(
  parameter int AW   = 32,
  parameter int IMMW = 16
) (
  input  logic            use_stride,
  input  logic [AW-1:0]   base,
  input  logic [AW-1:0]   stride,
  input  logic [IMMW-1:0] imm,
  output logic [AW-1:0]   sum
);
  logic [AW-1:0] imm_ext;
  logic [AW-1:0] addend;

  assign imm_ext = {{(AW-IMMW){imm[IMMW-1]}}, imm};
  assign addend  = use_stride ? stride : imm_ext;
  assign sum     = base + addend;
endmodule

// File: rtl/stride_advance_unit.sv
module stride_advance_unit #(
  parameter int AW   = 32,
  parameter int NREG = 32,
  parameter int IMMW = 16,
  parameter int DTW  = 3,
  localparam int IW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [IW-1:0]   cmd_rd,
  input  logic [IW-1:0]   cmd_rs,
  input  logic [IMMW-1:0] cmd_imm,
  input  logic [DTW-1:0]  cmd_dtype,
  output logic            busy,
  output logic [IW-1:0]   gpr_raddr,
  input  logic [AW-1:0]   gpr_rdata,
  output logic            gpr_we,
  output logic [IW-1:0]   gpr_waddr,
  output logic [AW-1:0]   gpr_wdata,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [AW-1:0]   req_addr,
  output logic [DTW-1:0]  req_dtype,
  output logic [IW-1:0]   req_slot
);
  import sau_pkg::*;

  st_e             state_q, state_d;
  op_e             op_q;
  logic [IW-1:0]   rd_q;
  logic [IMMW-1:0] imm_q;
  logic [DTW-1:0]  dtype_q;
  logic            accept;
  logic [AW-1:0]   stride_rd;
  logic [DTW-1:0]  dtype_rd;
  logic [AW-1:0]   sum;
  logic            stride_we;
  logic            dtype_we;

  assign accept    = cmd_valid && (state_q == ST_IDLE) && (op_e'(cmd_op) != OP_NONE);
  assign stride_we = (state_q == ST_EXEC) && (op_q == OP_STRIDE);
  assign dtype_we  = (state_q == ST_EXEC) && (op_q == OP_START);

  sau_slot_ram #(.W(AW), .DEPTH(NREG)) u_stride_ram (
    .clk   (clk),
    .we    (stride_we),
    .waddr (rd_q),
    .wdata (sum),
    .raddr (cmd_rd),
    .rdata (stride_rd)
  );

  sau_slot_ram #(.W(DTW), .DEPTH(NREG)) u_dtype_ram (
    .clk   (clk),
    .we    (dtype_we),
    .waddr (rd_q),
    .wdata (dtype_q),
    .raddr (cmd_rd),
    .rdata (dtype_rd)
  );

  sau_addr_adder #(.AW(AW), .IMMW(IMMW)) u_adder (
    .use_stride (op_q == OP_ADVANCE),
    .base       (gpr_rdata),
    .stride     (stride_rd),
    .imm        (imm_q),
    .sum        (sum)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_EXEC;
      ST_EXEC:  state_d = (op_q == OP_STRIDE) ? ST_IDLE : ST_ISSUE;
      ST_ISSUE: if (req_ready) state_d = ST_WB;
      ST_WB:    state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      busy      <= 1'b0;
      op_q      <= OP_NONE;
      rd_q      <= '0;
      imm_q     <= '0;
      dtype_q   <= '0;
      gpr_raddr <= '0;
      gpr_we    <= 1'b0;
      gpr_waddr <= '0;
      gpr_wdata <= '0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_dtype <= '0;
      req_slot  <= '0;
    end else begin
      state_q <= state_d;
      busy    <= (state_d != ST_IDLE);
      gpr_we  <= 1'b0;
      if (accept) begin
        op_q      <= op_e'(cmd_op);
        rd_q      <= cmd_rd;
        imm_q     <= cmd_imm;
        dtype_q   <= cmd_dtype;
        gpr_raddr <= (op_e'(cmd_op) == OP_ADVANCE) ? cmd_rd : cmd_rs;
      end
      if (state_q == ST_EXEC && op_q != OP_STRIDE) begin
        req_valid <= 1'b1;
        req_addr  <= sum;
        req_slot  <= rd_q;
        req_dtype <= (op_q == OP_START) ? dtype_q : dtype_rd;
      end
      if (state_q == ST_ISSUE && req_ready) begin
        req_valid <= 1'b0;
        gpr_we    <= 1'b1;
        gpr_waddr <= req_slot;
        gpr_wdata <= req_addr;
      end
    end
  end

  // R7: a stalled request keeps its address and stays valid
  p_req_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  // R7: write-back only follows a completed handshake
  p_wb_after_hs_r7: assert property (@(posedge clk) disable iff (rst)
    gpr_we |-> $past(req_valid && req_ready));

  // R2/R3: the address written back equals the one requested
  p_wb_data_r3: assert property (@(posedge clk) disable iff (rst)
    gpr_we |-> (gpr_wdata == $past(req_addr)));

  // R8: nothing leaves the unit while it is idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!req_valid && !gpr_we));

  // R1: a stride update never coincides with a request or write-back
  p_stride_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    stride_we |-> (!req_valid && !gpr_we));
endmodule

// File: tb/stride_advance_unit_tb_top.sv
`timescale 1ns/1ps
module stride_advance_unit_tb_top;
  localparam int AW = 32, NREG = 32, IMMW = 16, DTW = 3, IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic            cmd_valid = 1'b0;
  logic [1:0]      cmd_op = '0;
  logic [IW-1:0]   cmd_rd = '0, cmd_rs = '0;
  logic [IMMW-1:0] cmd_imm = '0;
  logic [DTW-1:0]  cmd_dtype = '0;
  logic            busy, gpr_we, req_valid;
  logic            req_ready = 1'b1;
  logic [IW-1:0]   gpr_raddr, gpr_waddr, req_slot;
  logic [AW-1:0]   gpr_rdata, gpr_wdata, req_addr;
  logic [DTW-1:0]  req_dtype;

  logic [AW-1:0] gpr [NREG];
  logic          tb_we = 1'b0;
  logic [IW-1:0] tb_waddr = '0;
  logic [AW-1:0] tb_wdata = '0;

  int total = 0, bad = 0, hs_n = 0;
  logic [AW-1:0]  cap_addr;
  logic [DTW-1:0] cap_dt;
  logic [IW-1:0]  cap_slot;

  stride_advance_unit dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_rd(cmd_rd), .cmd_rs(cmd_rs), .cmd_imm(cmd_imm), .cmd_dtype(cmd_dtype),
    .busy(busy), .gpr_raddr(gpr_raddr), .gpr_rdata(gpr_rdata),
    .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_dtype(req_dtype), .req_slot(req_slot)
  );

  assign gpr_rdata = gpr[gpr_raddr];

  always @(posedge clk) begin
    if (tb_we) gpr[tb_waddr] <= tb_wdata;
    else if (gpr_we) gpr[gpr_waddr] <= gpr_wdata;
    if (!rst && req_valid && req_ready) begin
      hs_n     = hs_n + 1;
      cap_addr = req_addr;
      cap_dt   = req_dtype;
      cap_slot = req_slot;
    end
  end

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_gpr(input int idx, input logic [AW-1:0] v);
    @(negedge clk);
    tb_we = 1'b1; tb_waddr = IW'(idx); tb_wdata = v;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
  endtask

  task automatic do_cmd(input int op, input int rd, input int rs, input int imm, input int dt);
    @(negedge clk);
    wait_idle();
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_rd = IW'(rd); cmd_rs = IW'(rs);
    cmd_imm = IMMW'(imm); cmd_dtype = DTW'(dt);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  task automatic expect_req(input string tag, input int n0, input int slot,
                            input logic [AW-1:0] addr, input int dt);
    chk({tag, " request count"}, AW'(hs_n), AW'(n0 + 1));
    chk({tag, " req_addr"}, cap_addr, addr);
    chk({tag, " req_dtype"}, AW'(cap_dt), AW'(dt));
    chk({tag, " req_slot"}, AW'(cap_slot), AW'(slot));
    chk({tag, " write-back"}, gpr[slot], addr);
  endtask

  task automatic t_reset();
    chk("R8 busy after reset", AW'(busy), 0);
    chk("R8 req_valid after reset", AW'(req_valid), 0);
    chk("R8 gpr_we after reset", AW'(gpr_we), 0);
  endtask

  task automatic t_stride_setup();
    int n0;
    set_gpr(3, 32'd100);
    n0 = hs_n;
    do_cmd(1, 5, 3, -96, 0);          // R1: stride[5] = 4
    chk("R1 no request from setup", AW'(hs_n), AW'(n0));
    chk("R1 source reg untouched", gpr[3], 32'd100);
  endtask

  task automatic t_start_timing();
    int n0;
    set_gpr(7, 32'h1000);
    n0 = hs_n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_rd = 5'd5; cmd_rs = 5'd7;
    cmd_imm = 16'h0010; cmd_dtype = 3'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 busy one cycle after accept", AW'(busy), 1);
    chk("R9 no request one cycle after accept", AW'(req_valid), 0);
    @(negedge clk);
    chk("R9 req_valid two edges after accept", AW'(req_valid), 1);
    @(negedge clk);
    chk("R9 gpr_we after handshake", AW'(gpr_we), 1);
    @(negedge clk);
    chk("R9 gpr_we single cycle", AW'(gpr_we), 0);
    chk("R9 busy released", AW'(busy), 0);
    expect_req("R2 start", n0, 5, 32'h1010, 2);
  endtask

  task automatic t_advance_up();
    int n0;
    n0 = hs_n;
    do_cmd(3, 5, 0, 0, 7);            // R4: dtype 7 must be ignored
    expect_req("R3 R4 advance 1", n0, 5, 32'h1014, 2);
    n0 = hs_n;
    do_cmd(3, 5, 0, 0, 0);
    expect_req("R3 advance 2", n0, 5, 32'h1018, 2);
  endtask

  task automatic t_pairing_down();
    int n0;
    set_gpr(8, 32'h2000);
    do_cmd(1, 6, 0, -8, 0);           // R6: negative stride
    do_cmd(2, 6, 8, 0, 1);
    n0 = hs_n;
    do_cmd(3, 6, 0, 0, 4);
    expect_req("R5 R6 downward advance", n0, 6, 32'h1FF8, 1);
    n0 = hs_n;
    do_cmd(3, 5, 0, 0, 0);
    expect_req("R5 other entry stride kept", n0, 5, 32'h101C, 2);
  endtask

  task automatic t_wrap();
    int n0;
    set_gpr(10, 32'hFFFF_FFF8);
    do_cmd(1, 9, 0, 16, 0);
    do_cmd(2, 9, 10, 0, 3);
    n0 = hs_n;
    do_cmd(3, 9, 0, 0, 0);
    expect_req("R6 wrap upward", n0, 9, 32'h0000_0008, 3);
    n0 = hs_n;
    do_cmd(2, 11, 0, -4, 5);
    expect_req("R6 negative offset", n0, 11, 32'hFFFF_FFFC, 5);
  endtask

  task automatic t_backpressure();
    int n0;
    n0 = hs_n;
    req_ready = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_rd = 5'd5; cmd_dtype = 3'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R7 req held valid", AW'(req_valid), 1);
      chk("R7 req addr stable", req_addr, 32'h1020);
      chk("R7 busy during stall", AW'(busy), 1);
      chk("R7 no write-back during stall", AW'(gpr_we), 0);
      chk("R7 register not advanced yet", gpr[5], 32'h101C);
      @(negedge clk);
    end
    req_ready = 1'b1;
    wait_idle();
    expect_req("R7 after release", n0, 5, 32'h1020, 2);
  endtask

  task automatic t_busy_ignore();
    int n0;
    set_gpr(12, 32'h55);
    set_gpr(13, 32'h700);
    n0 = hs_n;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd3; cmd_rd = 5'd6;
    @(negedge clk);
    cmd_op = 2'd2; cmd_rd = 5'd12; cmd_rs = 5'd13; cmd_imm = 16'h4;  // R8: while busy
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    expect_req("R8 only first command", n0, 6, 32'h1FF0, 1);
    chk("R8 ignored command left reg", gpr[12], 32'h55);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) gpr[i] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stride_setup();
    t_start_timing();
    t_advance_up();
    t_pairing_down();
    t_wrap();
    t_backpressure();
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule